// File: doc/BRIEF.md
# Rate-Timed Sample Queue for an Audio DAC

This block buffers audio samples between a host processor and a digital-to-analog converter. The host pushes 12-bit words into a sixteen-deep first-in first-out store through a write-only data port. An internal sample timer pulls one word per tick and places it in a DAC data register. The register holds that word until the next tick, and a one-cycle strobe marks each update. The block never stalls the converter. If the store runs dry, each tick presents again whatever word sits at the read position, and the read position does not move.

The system clock is the 960 kHz reference. A fixed prescaler divides by ten and then by four, which gives a 24 kHz base tick. A reloadable counter then divides that by an odd number from 1 to 15, picked by three bits of a control register. The same control write also latches three sample-and-hold controls and two tablet-axis enables as plain outputs, and it restarts the timer from zero. Two active-low flags report the state of the store: one goes low when the store holds data, and the other goes high only when the store is full.

Top module: `sfifo_dac`

## Requirements
- R1: Words leave the store in the order they were accepted, and the store holds up to 16 of them.
- R2: A data write while 16 words are held is discarded and leaves the queued contents and order unchanged.
- R3: On each sample tick, `dacValid` pulses high for one cycle and `dacData` takes the word at the read position. `dacData` is unchanged in every other cycle.
- R4: A tick while the store is empty outputs the word at the read position and leaves that position where it is. That word is stale data from an earlier fill, or zero after reset.
- R5: Ticks repeat every 40·(8·b12 + 4·b11 + 2·b10 + 1) clock cycles, where bN is bit N of the last control word.
- R6: A control write latches its upper byte. Bit 15 goes to `shSet`, bit 14 to `shChanA`, bit 13 to `shChanB`, bits 12..10 to `rateSel[2:0]` (bit 12 as the MSB), bit 9 to `tabletXEn` and bit 8 to `tabletYEn`. The low byte is ignored.
- R7: A control write restarts the timer. The next tick arrives exactly one full new period after the clock edge that takes the write, and a tick due at that same edge is suppressed.
- R8: `dataAvailN` is 0 when at least one word is held and 1 otherwise. `roomAvailN` is 1 only when 16 words are held.
- R9: Reset empties the store, zeroes every entry, clears the control outputs and `dacData`, and restarts the timer at divisor 1. The first tick comes 40 cycles after release.
- R10: A data write and a tick in the same cycle both take effect. The only exception is a write at a count of 16, which is still dropped even though the tick frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 960 kHz system clock |
| rstN | input | 1 | asynchronous active-low reset |
| fifoWrEn | input | 1 | push `fifoWrData` into the store this cycle |
| fifoWrData | input | 12 | sample word to queue |
| ctrlWrEn | input | 1 | load the control register and restart the timer |
| ctrlWrData | input | 16 | control word; only bits 15..8 are used |
| dacData | output | 12 | DAC data register |
| dacValid | output | 1 | one-cycle strobe on each DAC update |
| dataAvailN | output | 1 | low when the store is not empty |
| roomAvailN | output | 1 | high when the store is full |
| shSet | output | 1 | sample-and-hold set control |
| shChanA | output | 1 | sample-and-hold channel A control |
| shChanB | output | 1 | sample-and-hold channel B control |
| rateSel | output | 3 | odd-divisor select, divisor = 2·rateSel + 1 |
| tabletXEn | output | 1 | tablet X axis enable |
| tabletYEn | output | 1 | tablet Y axis enable |

## Verification
A wrong count or pointer shows up at the DAC port on the next tick: a word comes out of order, a dropped word reappears, or a stale word is repeated. The active-low flags show a wrong count at once, in the cycle after the faulty update. A divider fault moves the `dacValid` pulse away from its exact 40·divisor cycle slot, so the bench times every tick to the cycle. It does this for all eight divisors, after a restart in the middle of a period, and on release from reset.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int CTRL_W = 16;
  localparam int SEL_W  = 3;

  // strobes from the timer/control side to the storage side
  typedef struct packed {
    logic wrReq;   // host asks to queue a word
    logic drain;   // sample tick: move one word to the DAC register
  } fifoStrobeT;
endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int PRE_DIV = 10,
  parameter int MID_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoWrEn,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output fifoStrobeT        strobes,
  output logic              shSet,
  output logic              shChanA,
  output logic              shChanB,
  output logic [SEL_W-1:0]  rateSel,
  output logic              tabletXEn,
  output logic              tabletYEn
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int MID_W = (MID_DIV > 1) ? $clog2(MID_DIV) : 1;
  localparam int ODD_W = SEL_W + 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
  localparam logic [MID_W-1:0] MID_LAST = MID_W'(MID_DIV - 1);

  logic [7:0]       ctrlReg;
  logic [PRE_W-1:0] preCnt;
  logic [MID_W-1:0] midCnt;
  logic [ODD_W-1:0] oddCnt;
  logic             preWrap, midWrap, baseTick, oddZero, sampleTick;
  logic [ODD_W-1:0] reloadVal;
  logic             unusedLowByte;

  assign unusedLowByte = ^ctrlWrData[7:0];

  assign shSet     = ctrlReg[7];
  assign shChanA   = ctrlReg[6];
  assign shChanB   = ctrlReg[5];
  assign rateSel   = ctrlReg[4:2];
  assign tabletXEn = ctrlReg[1];
  assign tabletYEn = ctrlReg[0];

  assign preWrap    = (preCnt == PRE_LAST);
  assign midWrap    = (midCnt == MID_LAST);
  assign baseTick   = preWrap && midWrap;
  assign oddZero    = (oddCnt == '0);
  assign reloadVal  = {rateSel, 1'b0};   // divisor - 1
  assign sampleTick = baseTick && oddZero;

  assign strobes.wrReq = fifoWrEn;
  assign strobes.drain = sampleTick && !ctrlWrEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      preCnt  <= '0;
      midCnt  <= '0;
      oddCnt  <= '0;
    end else if (ctrlWrEn) begin
      ctrlReg <= ctrlWrData[15:8];
      preCnt  <= '0;
      midCnt  <= '0;
      oddCnt  <= {ctrlWrData[12:10], 1'b0};
    end else begin
      preCnt <= preWrap ? '0 : preCnt + 1'b1;
      if (preWrap) midCnt <= midWrap ? '0 : midCnt + 1'b1;
      if (baseTick) oddCnt <= oddZero ? reloadVal : oddCnt - 1'b1;
    end
  end

  // R5
  odd_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    oddCnt <= {rateSel, 1'b0});
  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.drain |=> !strobes.drain);
  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn |=> !strobes.drain);
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobeT       strobes,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] dacData,
  output logic             dacValid,
  output logic             dataAvailN,
  output logic             roomAvailN
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] headPtr, tailPtr;
  logic [CNT_W-1:0] count;
  logic             isFull, isEmpty, doPush, doAdvance;

  assign isFull    = (count == FULL_CNT);
  assign isEmpty   = (count == '0);
  assign doPush    = strobes.wrReq && !isFull;
  assign doAdvance = strobes.drain && !isEmpty;

  assign dataAvailN = isEmpty;
  assign roomAvailN = isFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      headPtr  <= '0;
      tailPtr  <= '0;
      count    <= '0;
      dacData  <= '0;
      dacValid <= 1'b0;
    end else begin
      dacValid <= strobes.drain;
      if (strobes.drain) dacData <= mem[tailPtr];
      if (doPush) begin
        mem[headPtr] <= wrData;
        headPtr      <= headPtr + 1'b1;
      end
      if (doAdvance) tailPtr <= tailPtr + 1'b1;
      case ({doPush, doAdvance})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && strobes.wrReq && !strobes.drain) |=> ($stable(count) && $stable(headPtr)));
  // R3
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.drain |=> dacValid);
  // R3
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.drain |=> $stable(dacData));
  // R4
  empty_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.drain && isEmpty) |=> $stable(tailPtr));
  // R8
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dataAvailN && roomAvailN));
  // R10
  both_ops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrReq && strobes.drain && !isEmpty && !isFull) |=> $stable(count));
endmodule

// File: rtl/sfifo_dac.sv
module sfifo_dac
  import sfifo_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int WIDTH   = 12,
  parameter int PRE_DIV = 10,
  parameter int MID_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoWrEn,
  input  logic [WIDTH-1:0]  fifoWrData,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output logic [WIDTH-1:0]  dacData,
  output logic              dacValid,
  output logic              dataAvailN,
  output logic              roomAvailN,
  output logic              shSet,
  output logic              shChanA,
  output logic              shChanB,
  output logic [SEL_W-1:0]  rateSel,
  output logic              tabletXEn,
  output logic              tabletYEn
);
  fifoStrobeT strobes;

  sfifo_ctrl #(.PRE_DIV(PRE_DIV), .MID_DIV(MID_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoWrEn(fifoWrEn), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .strobes(strobes), .shSet(shSet),
    .shChanA(shChanA), .shChanB(shChanB), .rateSel(rateSel),
    .tabletXEn(tabletXEn), .tabletYEn(tabletYEn)
  );

  sfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(fifoWrData),
    .dacData(dacData), .dacValid(dacValid), .dataAvailN(dataAvailN),
    .roomAvailN(roomAvailN)
  );
endmodule

// File: tb/sfifo_dac_tb.sv
module sfifo_dac_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fifoWrEn = 1'b0;
  logic [11:0] fifoWrData = '0;
  logic        ctrlWrEn = 1'b0;
  logic [15:0] ctrlWrData = '0;
  logic [11:0] dacData;
  logic        dacValid, dataAvailN, roomAvailN;
  logic        shSet, shChanA, shChanB, tabletXEn, tabletYEn;
  logic [2:0]  rateSel;

  int checks = 0;
  int errors = 0;
  int edgeNo = 0;
  int t0 = 0;
  string popTag = "R4";

  // independent model of the queue
  int mMem [16];
  int mHead = 0, mTail = 0, mCount = 0;
  logic wrSeen = 1'b0;
  int   dSeen = 0;

  sfifo_dac u_dut (
    .clk(clk), .rstN(rstN), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .dacData(dacData),
    .dacValid(dacValid), .dataAvailN(dataAvailN), .roomAvailN(roomAvailN),
    .shSet(shSet), .shChanA(shChanA), .shChanB(shChanB), .rateSel(rateSel),
    .tabletXEn(tabletXEn), .tabletYEn(tabletYEn)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    edgeNo <= edgeNo + 1;
    wrSeen <= fifoWrEn && rstN;
    dSeen  <= int'(fifoWrData);
  end

  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mMem[i] = 0;
      mHead = 0; mTail = 0; mCount = 0;
    end else begin
      automatic bit fullBefore = (mCount == 16);
      if (dacValid) begin
        chk(int'(dacData) == mMem[mTail], (mCount == 0) ? "R4" : popTag,
            int'(dacData), mMem[mTail]);
        if (mCount > 0) begin mTail = (mTail + 1) % 16; mCount--; end
      end
      if (wrSeen && !fullBefore) begin
        mMem[mHead] = dSeen; mHead = (mHead + 1) % 16; mCount++;
      end
      chk(dataAvailN == (mCount == 0), "R8 dataAvailN", int'(dataAvailN), int'(mCount == 0));
      chk(roomAvailN == (mCount == 16), "R8 roomAvailN", int'(roomAvailN), int'(mCount == 16));
    end
  end

  task automatic writeCtrl(input logic [15:0] w);
    @(negedge clk);
    ctrlWrData = w; ctrlWrEn = 1'b1;
    @(negedge clk);
    ctrlWrEn = 1'b0;
    t0 = edgeNo;
  endtask

  task automatic pushWord(input int w);
    fifoWrData = w[11:0]; fifoWrEn = 1'b1;
    @(negedge clk);
    fifoWrEn = 1'b0;
  endtask

  task automatic waitTick(output int el);
    int n = 0;
    do begin @(negedge clk); n++; end while (!dacValid && n < 1000);
    el = edgeNo - t0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", edgeNo, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int el;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(dacData == 0 && dacValid == 0, "R9 dac", int'(dacData), 0);
    chk(dataAvailN == 1 && roomAvailN == 0, "R9 flags", int'({dataAvailN, roomAvailN}), 2);
    chk({shSet, shChanA, shChanB, rateSel, tabletXEn, tabletYEn} == 0, "R9 ctrl",
        int'({shSet, shChanA, shChanB, rateSel, tabletXEn, tabletYEn}), 0);
    rstN = 1'b1;
    t0 = edgeNo;
    waitTick(el);
    chk(el == 40, "R9 first tick", el, 40);

    // R5/R6: sweep all eight divisors with varied auxiliary bits
    for (int s = 0; s < 8; s++) begin
      automatic logic [15:0] w;
      automatic int div = 2 * s + 1;
      w = 16'h00A5;
      w[15] = s[0]; w[14] = s[1]; w[13] = s[2];
      w[12] = s[2]; w[11] = s[1]; w[10] = s[0];
      w[9] = ~s[0]; w[8] = s[1] ^ s[2];
      writeCtrl(w);
      chk({shSet, shChanA, shChanB, rateSel, tabletXEn, tabletYEn} == w[15:8], "R6 fields",
          int'({shSet, shChanA, shChanB, rateSel, tabletXEn, tabletYEn}), int'(w[15:8]));
      waitTick(el);
      chk(el == 40 * div, "R5 first period", el, 40 * div);
      t0 = edgeNo;
      waitTick(el);
      chk(el == 40 * div, "R5 period", el, 40 * div);
    end

    // R7: a rewrite in mid-period restarts the timer
    writeCtrl(16'h0400);
    repeat (50) @(negedge clk);
    writeCtrl(16'h0400);
    waitTick(el);
    chk(el == 120, "R7 restart", el, 120);

    // R1/R2: fill past full at divisor 1, then drain
    popTag = "R2";
    writeCtrl(16'h0000);
    for (int k = 0; k < 17; k++) begin
      pushWord((k * 273 + 5) & 12'hFFF);
      if (k == 15) chk(roomAvailN == 1, "R2 full flag", int'(roomAvailN), 1);
    end
    chk(roomAvailN == 1, "R2 drop keeps full", int'(roomAvailN), 1);
    popTag = "R1";
    for (int k = 0; k < 17; k++) waitTick(el);
    chk(dataAvailN == 1, "R1 drained", int'(dataAvailN), 1);

    // R10: write and tick together, first at full, then with room
    popTag = "R10";
    writeCtrl(16'h0000);
    for (int k = 0; k < 16; k++) pushWord((k * 91 + 7) & 12'hFFF);
    repeat (23) @(negedge clk);
    pushWord(12'hABC);
    chk(dacValid == 1, "R10 tick aligned", int'(dacValid), 1);
    chk(roomAvailN == 0, "R10 full write dropped", int'(roomAvailN), 0);
    repeat (39) @(negedge clk);
    pushWord(12'h5A5);
    chk(dacValid == 1 && roomAvailN == 0, "R10 both applied",
        int'({dacValid, roomAvailN}), 2);
    for (int k = 0; k < 16; k++) waitTick(el);

    // R9: reset in the middle of a fill
    popTag = "R9";
    writeCtrl(16'hFF00);
    for (int k = 0; k < 3; k++) pushWord(k + 100);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk(dataAvailN == 1 && rateSel == 0, "R9 mid reset", int'({dataAvailN, rateSel}), 8);
    rstN = 1'b1;
    t0 = edgeNo;
    waitTick(el);
    chk(el == 40 && dacData == 0, "R9 restart tick", el, 40);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule